// File: doc/BRIEF.md
# I2C Single-Byte Register Transaction Sequencer

This block turns a one-line command (read or write, device address byte, register offset, write data) into the exact series of bit-level operations that an I2C bit engine needs to carry out a single-byte register access. It shifts every byte most significant bit first and checks the acknowledge after each byte the controller sends. A read finishes with a not-acknowledge driven by the controller and returns the byte that was read. A write returns only a status.

Any failure ends the current attempt. A failure is a missing acknowledge or a line fault reported by the engine. The block then asks the engine for a bus-clear operation, waits out a back-off interval and, if attempts remain, starts again from the START condition. Reads and writes each have their own attempt limit. While a command is being handled the block raises a bit-bang enable flag. It drops that flag when it delivers the one-cycle response, whatever the result. The timing of individual SCL/SDA edges belongs to the engine and is not part of this block.

The engine interface carries one operation at a time. The codes on `op_code` are 1 = START, 2 = STOP, 3 = write bit (`op_bit` is the level to drive), 4 = read bit (`op_bit` is 1, meaning SDA is released) and 5 = bus clear. The engine answers with a one-cycle `op_done`, which carries `op_rbit` (the sampled SDA) and `op_err` (a line fault).

Top module: `i2cseq_top`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress. A command is taken on a clock edge with `cmd_valid` and `cmd_ready` both high. Each engine operation keeps `op_valid` high with a stable code and bit until `op_done`. `op_valid` is then low for at least one cycle before the next operation.
- R2: Every byte the controller sends appears as eight write-bit operations (code 3), most significant bit first. A read-bit operation (code 4) for the acknowledge follows, with `op_bit` = 1. Received data bits are assembled most significant bit first.
- R3: A successful write issues exactly these operations: START, the address byte as given, ACK, the offset byte, ACK, the data byte, ACK, STOP. It then responds with status 0.
- R4: A successful read issues exactly these operations:
  - START, the address byte as given, ACK, the offset byte, ACK;
  - a second START, the address byte with bit 0 forced to 1, ACK;
  - eight read-bit operations, then one write-bit operation with bit 1 (NACK), then STOP.
- R5: A successful read responds with status 0, and `rsp_rdata` holds the eight received bits.
- R6: A sampled 1 on any acknowledge read-bit ends the attempt at once. The next operation is a bus clear (code 5), and no further byte of that attempt is sent.
- R7: After a bus clear completes, no operation is issued for at least `BACKOFF_CYCLES` cycles. If attempts remain, the next operation is a START.
- R8: A read makes at most `RD_TRIES` attempts (default 10) and a write at most `WR_TRIES` attempts (default 1). Every failed attempt is followed by a bus clear and a back-off, including the last one. The response then carries the status of the last attempt: 1 = no acknowledge, 2 = line fault.
- R9: `bb_en` goes high on the edge that takes a command and stays high during every engine operation. It is low on the edge that raises `rsp_valid`.
- R10: `rsp_rdata` is 0 for writes and for every failed response. The read byte is cleared at the start of each attempt, so a read that succeeds after a retry reports only the bits of that attempt.
- R11: An `op_err` on any START, STOP or byte operation ends the attempt with status 2. It is followed by the same bus clear, back-off and retry handling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | BYTE_W | Device address byte (bit 0 = 0 expected) |
| cmd_off | input | BYTE_W | Register offset |
| cmd_wdata | input | BYTE_W | Data for a write |
| op_valid | output | 1 | Engine operation requested |
| op_code | output | 3 | Operation code (1..5, see above) |
| op_bit | output | 1 | Level to drive for a write-bit, 1 otherwise |
| op_done | input | 1 | Engine finished the operation (one cycle) |
| op_rbit | input | 1 | SDA level sampled by a read-bit |
| op_err | input | 1 | Engine reports a line fault for the operation |
| bb_en | output | 1 | Bit-bang enable, high for the whole command |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 0 = ok, 1 = no acknowledge, 2 = line fault |
| rsp_rdata | output | BYTE_W | Read byte, 0 unless a read succeeded |

## Verification
The hardest cases to reach from the ports are a read that fails one or more attempts and then succeeds, and a read that uses up all ten attempts. In both, the retry count, the bus-clear ordering, the back-off gap and the clearing of the read byte all interact. The bench plays the target device at operation level and keeps budgets of refused address acknowledges and of line faults reported on STOP, so a chosen number of attempts fail at a chosen point before the device answers normally. Each whole operation stream is logged and compared, entry by entry, with a stream built from the requirements. The exact operation counts of aborted attempts are checked in the same way.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // Engine operation codes (values are visible on op_code)
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WBIT  = 3'd3,
    OP_RBIT  = 3'd4,
    OP_CLEAR = 3'd5
  } op_e;

  // Response status codes
  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_NACK = 2'd1,
    ST_LINE = 2'd2
  } stat_e;

endpackage

// File: rtl/i2cseq_byte_xfer.sv
module i2cseq_byte_xfer
  import i2cseq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              rx_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              req,
  output op_e               code,
  output logic              bit_out,
  input  logic              op_done,
  input  logic              op_rbit,
  input  logic              op_err,
  output logic              done,
  output stat_e             result,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int CW = $clog2(BYTE_W);

  typedef enum logic [1:0] {BX_IDLE, BX_DATA, BX_ACK} bx_state_e;

  bx_state_e         st;
  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              rxm;

  // Operation presented to the engine, decoded from registered state
  always_comb begin
    code    = OP_NONE;
    bit_out = 1'b1;
    case (st)
      BX_DATA: begin
        code    = rxm ? OP_RBIT : OP_WBIT;
        bit_out = rxm ? 1'b1 : sh[BYTE_W-1];
      end
      BX_ACK: begin
        code    = rxm ? OP_WBIT : OP_RBIT;
        bit_out = 1'b1;
      end
      default: begin
        code    = OP_NONE;
        bit_out = 1'b1;
      end
    endcase
  end

  assign rx_byte = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= BX_IDLE;
      req    <= 1'b0;
      done   <= 1'b0;
      result <= ST_OK;
      sh     <= '0;
      cnt    <= '0;
      rxm    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        BX_IDLE: begin
          if (go) begin
            sh  <= rx_mode ? '0 : tx_byte;
            cnt <= CW'(BYTE_W - 1);
            rxm <= rx_mode;
            st  <= BX_DATA;
          end
        end
        BX_DATA: begin
          if (!req) begin
            req <= 1'b1;
          end else if (op_done) begin
            req <= 1'b0;
            if (op_err) begin
              result <= ST_LINE;
              done   <= 1'b1;
              st     <= BX_IDLE;
            end else begin
              sh <= rxm ? {sh[BYTE_W-2:0], op_rbit} : {sh[BYTE_W-2:0], 1'b0};
              if (cnt == '0) st <= BX_ACK;
              else           cnt <= cnt - 1'b1;
            end
          end
        end
        BX_ACK: begin
          if (!req) begin
            req <= 1'b1;
          end else if (op_done) begin
            req  <= 1'b0;
            done <= 1'b1;
            st   <= BX_IDLE;
            if (op_err)              result <= ST_LINE;
            else if (!rxm && op_rbit) result <= ST_NACK;
            else                     result <= ST_OK;
          end
        end
        default: st <= BX_IDLE;
      endcase
    end
  end

  // R1
  held_op_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !op_done) |=> (req && $stable(code) && $stable(bit_out)));

  // R1
  gap_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (req && op_done) |=> !req);

endmodule

// File: rtl/i2cseq_backoff.sv
module i2cseq_backoff #(
  parameter int unsigned CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fin
);

  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        cnt  <= CW'(CYCLES - 1);
        busy <= 1'b1;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R7
  fin_only_after_count_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> $past(busy));

  // R7
  keeps_counting_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && cnt != '0) |=> (busy && !fin));

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int RD_TRIES = 10,
  parameter int WR_TRIES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_rd,
  input  logic [BYTE_W-1:0] cmd_dev,
  input  logic [BYTE_W-1:0] cmd_off,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              op_done,
  input  logic              op_err,
  output logic              c_req,
  output op_e               c_code,
  output logic              bx_go,
  output logic              bx_rx,
  output logic [BYTE_W-1:0] bx_byte,
  input  logic              bx_done,
  input  stat_e             bx_result,
  input  logic [BYTE_W-1:0] bx_rx_byte,
  output logic              tm_start,
  input  logic              tm_fin,
  output logic              bb_en,
  output logic              rsp_valid,
  output stat_e             rsp_status,
  output logic [BYTE_W-1:0] rsp_rdata
);

  localparam int MAXT = (RD_TRIES > WR_TRIES) ? RD_TRIES : WR_TRIES;
  localparam int AW   = $clog2(MAXT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START1, S_ADDRW, S_OFFS, S_START2, S_ADDRR,
    S_RDATA, S_WDATA, S_STOP, S_CLEAR, S_WAIT
  } seq_state_e;

  seq_state_e        st;
  logic              rd_l;
  logic [BYTE_W-1:0] dev_l, off_l, wd_l, rdata;
  stat_e             last_stat;
  logic [AW-1:0]     tries, tries_nxt, lim;

  assign cmd_ready = (st == S_IDLE);
  assign tries_nxt = tries + AW'(1);
  assign lim       = rd_l ? AW'(RD_TRIES) : AW'(WR_TRIES);

  always_comb begin
    case (st)
      S_START1, S_START2: c_code = OP_START;
      S_STOP:             c_code = OP_STOP;
      S_CLEAR:            c_code = OP_CLEAR;
      default:            c_code = OP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      c_req      <= 1'b0;
      bx_go      <= 1'b0;
      bx_rx      <= 1'b0;
      bx_byte    <= '0;
      tm_start   <= 1'b0;
      bb_en      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rdata  <= '0;
      rdata      <= '0;
      last_stat  <= ST_OK;
      tries      <= '0;
      rd_l       <= 1'b0;
      dev_l      <= '0;
      off_l      <= '0;
      wd_l       <= '0;
    end else begin
      bx_go     <= 1'b0;
      tm_start  <= 1'b0;
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            rd_l  <= cmd_rd;
            dev_l <= cmd_dev;
            off_l <= cmd_off;
            wd_l  <= cmd_wdata;
            tries <= '0;
            rdata <= '0;
            bb_en <= 1'b1;
            st    <= S_START1;
          end
        end
        S_START1: begin
          if (!c_req) begin
            c_req <= 1'b1;
          end else if (op_done) begin
            c_req <= 1'b0;
            if (op_err) begin
              last_stat <= ST_LINE;
              rdata     <= '0;
              st        <= S_CLEAR;
            end else begin
              bx_go   <= 1'b1;
              bx_rx   <= 1'b0;
              bx_byte <= dev_l;
              st      <= S_ADDRW;
            end
          end
        end
        S_ADDRW: begin
          if (bx_done) begin
            if (bx_result != ST_OK) begin
              last_stat <= bx_result;
              rdata     <= '0;
              st        <= S_CLEAR;
            end else begin
              bx_go   <= 1'b1;
              bx_rx   <= 1'b0;
              bx_byte <= off_l;
              st      <= S_OFFS;
            end
          end
        end
        S_OFFS: begin
          if (bx_done) begin
            if (bx_result != ST_OK) begin
              last_stat <= bx_result;
              rdata     <= '0;
              st        <= S_CLEAR;
            end else if (rd_l) begin
              st <= S_START2;
            end else begin
              bx_go   <= 1'b1;
              bx_rx   <= 1'b0;
              bx_byte <= wd_l;
              st      <= S_WDATA;
            end
          end
        end
        S_START2: begin
          if (!c_req) begin
            c_req <= 1'b1;
          end else if (op_done) begin
            c_req <= 1'b0;
            if (op_err) begin
              last_stat <= ST_LINE;
              rdata     <= '0;
              st        <= S_CLEAR;
            end else begin
              bx_go   <= 1'b1;
              bx_rx   <= 1'b0;
              bx_byte <= {dev_l[BYTE_W-1:1], 1'b1};
              st      <= S_ADDRR;
            end
          end
        end
        S_ADDRR: begin
          if (bx_done) begin
            if (bx_result != ST_OK) begin
              last_stat <= bx_result;
              rdata     <= '0;
              st        <= S_CLEAR;
            end else begin
              bx_go   <= 1'b1;
              bx_rx   <= 1'b1;
              bx_byte <= '0;
              st      <= S_RDATA;
            end
          end
        end
        S_RDATA: begin
          if (bx_done) begin
            if (bx_result != ST_OK) begin
              last_stat <= bx_result;
              rdata     <= '0;
              st        <= S_CLEAR;
            end else begin
              rdata <= bx_rx_byte;
              st    <= S_STOP;
            end
          end
        end
        S_WDATA: begin
          if (bx_done) begin
            if (bx_result != ST_OK) begin
              last_stat <= bx_result;
              rdata     <= '0;
              st        <= S_CLEAR;
            end else begin
              st <= S_STOP;
            end
          end
        end
        S_STOP: begin
          if (!c_req) begin
            c_req <= 1'b1;
          end else if (op_done) begin
            c_req <= 1'b0;
            if (op_err) begin
              last_stat <= ST_LINE;
              rdata     <= '0;
              st        <= S_CLEAR;
            end else begin
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
              rsp_rdata  <= rdata;
              bb_en      <= 1'b0;
              st         <= S_IDLE;
            end
          end
        end
        S_CLEAR: begin
          if (!c_req) begin
            c_req <= 1'b1;
          end else if (op_done) begin
            c_req    <= 1'b0;
            tm_start <= 1'b1;
            st       <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (tm_fin) begin
            if (tries_nxt < lim) begin
              tries <= tries_nxt;
              rdata <= '0;
              st    <= S_START1;
            end else begin
              rsp_valid  <= 1'b1;
              rsp_status <= last_stat;
              rsp_rdata  <= '0;
              bb_en      <= 1'b0;
              st         <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  tries_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |-> (tries < lim));

  // R6
  abort_to_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bx_done && bx_result != ST_OK) |=> (st == S_CLEAR));

  // R9
  idle_flag_low_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !bb_en);

  // R10
  fail_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != ST_OK) |-> (rsp_rdata == '0));

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter int          BYTE_W         = 8,
  parameter int          RD_TRIES       = 10,
  parameter int          WR_TRIES       = 1,
  parameter int unsigned BACKOFF_CYCLES = 25_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_rd,
  input  logic [BYTE_W-1:0] cmd_dev,
  input  logic [BYTE_W-1:0] cmd_off,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic              op_bit,
  input  logic              op_done,
  input  logic              op_rbit,
  input  logic              op_err,
  output logic              bb_en,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [BYTE_W-1:0] rsp_rdata
);

  logic              c_req, bx_req, bx_go, bx_rx, bx_done, bx_bit;
  logic              tm_start, tm_fin;
  op_e               c_code, bx_code, sel_code;
  stat_e             bx_result, rsp_stat_e;
  logic [BYTE_W-1:0] bx_byte, bx_rx_byte;

  i2cseq_ctrl #(
    .BYTE_W   (BYTE_W),
    .RD_TRIES (RD_TRIES),
    .WR_TRIES (WR_TRIES)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_rd     (cmd_rd),
    .cmd_dev    (cmd_dev),
    .cmd_off    (cmd_off),
    .cmd_wdata  (cmd_wdata),
    .op_done    (op_done),
    .op_err     (op_err),
    .c_req      (c_req),
    .c_code     (c_code),
    .bx_go      (bx_go),
    .bx_rx      (bx_rx),
    .bx_byte    (bx_byte),
    .bx_done    (bx_done),
    .bx_result  (bx_result),
    .bx_rx_byte (bx_rx_byte),
    .tm_start   (tm_start),
    .tm_fin     (tm_fin),
    .bb_en      (bb_en),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_stat_e),
    .rsp_rdata  (rsp_rdata)
  );

  i2cseq_byte_xfer #(
    .BYTE_W (BYTE_W)
  ) u_byte (
    .clk     (clk),
    .rst     (rst),
    .go      (bx_go),
    .rx_mode (bx_rx),
    .tx_byte (bx_byte),
    .req     (bx_req),
    .code    (bx_code),
    .bit_out (bx_bit),
    .op_done (op_done),
    .op_rbit (op_rbit),
    .op_err  (op_err),
    .done    (bx_done),
    .result  (bx_result),
    .rx_byte (bx_rx_byte)
  );

  i2cseq_backoff #(
    .CYCLES (BACKOFF_CYCLES)
  ) u_backoff (
    .clk   (clk),
    .rst   (rst),
    .start (tm_start),
    .fin   (tm_fin)
  );

  assign sel_code   = bx_req ? bx_code : c_code;
  assign op_valid   = c_req | bx_req;
  assign op_code    = sel_code;
  assign op_bit     = bx_req ? bx_bit : 1'b1;
  assign rsp_status = rsp_stat_e;

  // R1
  one_issuer_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({c_req, bx_req}));

  // R9
  flag_during_op_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> bb_en);

  // R7
  silent_backoff_chk: assert property (@(posedge clk) disable iff (rst)
    tm_start |=> !op_valid);

endmodule

// File: tb/i2cseq_top_bench.sv
module i2cseq_top_bench;

  localparam int BACKOFF = 16;
  localparam logic [6:0] DEV7 = 7'h50;
  localparam logic [2:0] C_START = 3'd1, C_STOP = 3'd2, C_WBIT = 3'd3,
                         C_RBIT = 3'd4, C_CLEAR = 3'd5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0, cmd_rd = 1'b0;
  logic [7:0] cmd_dev = '0, cmd_off = '0, cmd_wdata = '0;
  logic       cmd_ready, op_valid, op_bit, bb_en, rsp_valid;
  logic [2:0] op_code;
  logic       op_done = 1'b0, op_rbit = 1'b1, op_err = 1'b0;
  logic [1:0] rsp_status;
  logic [7:0] rsp_rdata;

  i2cseq_top #(
    .BYTE_W(8), .RD_TRIES(10), .WR_TRIES(1), .BACKOFF_CYCLES(BACKOFF)
  ) u_i2cseq_top (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rd(cmd_rd), .cmd_dev(cmd_dev), .cmd_off(cmd_off), .cmd_wdata(cmd_wdata),
    .op_valid(op_valid), .op_code(op_code), .op_bit(op_bit), .op_done(op_done),
    .op_rbit(op_rbit), .op_err(op_err), .bb_en(bb_en), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int pass_cnt = 0, fail_cnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h96;
  endfunction

  // Operation log and target model state
  logic [2:0] lg_code [0:255];
  logic       lg_bit  [0:255];
  int nlog = 0, clear_cnt = 0, nack_left = 0, err_left = 0;
  int viol_bb = 0, viol_busy = 0, viol_gap = 0, viol_backoff = 0;
  int clear_cyc = 0;
  bit gap_armed = 0;
  int phase = 0, bcnt = 0, bidx = 0;
  logic [7:0] sh = '0, off_r = '0, wr_seen = '0;
  logic rdm = 1'b0;

  task automatic respond(input logic [2:0] c, input logic b);
    logic ackit;
    op_rbit = 1'b1;
    op_err  = 1'b0;
    case (c)
      C_START: begin phase = 1; bcnt = 0; bidx = 0; end
      C_STOP: begin
        phase = 0;
        if (err_left > 0) begin op_err = 1'b1; err_left--; end
      end
      C_CLEAR: phase = 0;
      C_WBIT: begin
        if (phase == 1) begin
          sh = {sh[6:0], b}; bcnt++;
          if (bcnt == 8) phase = 2;
        end else if (phase == 4) phase = 0;
      end
      C_RBIT: begin
        if (phase == 2) begin
          ackit = 1'b1;
          if (bidx == 0) begin
            ackit = (sh[7:1] == DEV7);
            if (ackit && !sh[0] && nack_left > 0) begin ackit = 1'b0; nack_left--; end
            rdm = sh[0];
          end else if (bidx == 1) off_r = sh;
          else wr_seen = sh;
          op_rbit = !ackit;
          bidx++; bcnt = 0;
          if (!ackit) phase = 0;
          else if (bidx == 1 && rdm) begin phase = 3; sh = memf(off_r); end
          else phase = 1;
        end else if (phase == 3) begin
          op_rbit = sh[7]; sh = {sh[6:0], 1'b0}; bcnt++;
          if (bcnt == 8) phase = 4;
        end
      end
      default: ;
    endcase
  endtask

  // Single-cycle engine plus target device
  initial begin
    forever begin
      @(negedge clk);
      if (op_done) begin
        op_done = 1'b0; op_err = 1'b0; op_rbit = 1'b1;
        if (op_valid) viol_gap++;
      end else if (op_valid && !rst) begin
        if (!bb_en) viol_bb++;
        if (cmd_ready) viol_busy++;
        if (gap_armed) begin
          if (cyc - clear_cyc < BACKOFF) viol_backoff++;
          gap_armed = 0;
        end
        if (nlog < 256) begin lg_code[nlog] = op_code; lg_bit[nlog] = op_bit; end
        nlog++;
        if (op_code == C_CLEAR) begin clear_cnt++; clear_cyc = cyc; gap_armed = 1; end
        respond(op_code, op_bit);
        op_done = 1'b1;
      end
    end
  end

  // Expected stream
  logic [2:0] ec [0:255];
  logic       eb [0:255];
  int ne = 0;

  task automatic push(input logic [2:0] c, input logic b);
    ec[ne] = c; eb[ne] = b; ne++;
  endtask

  task automatic push_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) push(C_WBIT, v[i]);
    push(C_RBIT, 1'b1);
  endtask

  task automatic build_write(input logic [7:0] d, o, w);
    ne = 0;
    push(C_START, 1'b1); push_byte(d); push_byte(o); push_byte(w); push(C_STOP, 1'b1);
  endtask

  task automatic build_read(input logic [7:0] d, o);
    ne = 0;
    push(C_START, 1'b1); push_byte(d); push_byte(o);
    push(C_START, 1'b1); push_byte({d[7:1], 1'b1});
    for (int i = 0; i < 8; i++) push(C_RBIT, 1'b1);
    push(C_WBIT, 1'b1); push(C_STOP, 1'b1);
  endtask

  task automatic check_seq(input string req);
    int bad;
    bad = -1;
    if (nlog != ne) bad = 999;
    else for (int i = 0; i < ne; i++)
      if (bad < 0 && (lg_code[i] != ec[i] || lg_bit[i] != eb[i])) bad = i;
    check(bad < 0, req, "operation stream (len / first bad index)", (bad < 0) ? nlog : bad, ne);
  endtask

  logic [1:0] r_st;
  logic [7:0] r_data;
  logic       bb_acc, bb_rsp;

  task automatic run_cmd(input logic rd, input logic [7:0] d, o, w);
    nlog = 0; clear_cnt = 0; gap_armed = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_rd = rd; cmd_dev = d; cmd_off = o; cmd_wdata = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    bb_acc = bb_en;
    while (!rsp_valid) @(negedge clk);
    r_st = rsp_status; r_data = rsp_rdata; bb_rsp = bb_en;
  endtask

  task automatic t_reset;
    check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
    check(bb_en == 1'b0, "R9", "bb_en after reset", bb_en, 0);
    check(op_valid == 1'b0, "R1", "op_valid after reset", op_valid, 0);
    check(rsp_valid == 1'b0, "R5", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_write_ok;
    run_cmd(1'b0, 8'hA0, 8'h3C, 8'hA5);
    build_write(8'hA0, 8'h3C, 8'hA5);
    check_seq("R3");
    check(r_st == 2'd0, "R3", "write status", r_st, 0);
    check(wr_seen == 8'hA5, "R2", "data byte seen by target", wr_seen, 8'hA5);
    check(r_data == 8'h00, "R10", "write rdata", r_data, 0);
    check(bb_acc == 1'b1, "R9", "bb_en after accept", bb_acc, 1);
    check(bb_rsp == 1'b0, "R9", "bb_en at response", bb_rsp, 0);
    check(clear_cnt == 0, "R6", "no clear on success", clear_cnt, 0);
  endtask

  task automatic t_read_ok(input logic [7:0] o);
    run_cmd(1'b1, 8'hA0, o, 8'h00);
    build_read(8'hA0, o);
    check_seq("R4");
    check(r_st == 2'd0, "R5", "read status", r_st, 0);
    check(r_data == memf(o), "R5", "read data", r_data, memf(o));
  endtask

  task automatic t_read_retry;
    nack_left = 3;
    run_cmd(1'b1, 8'hA0, 8'h47, 8'h00);
    check(r_st == 2'd0, "R8", "read after 3 refusals status", r_st, 0);
    check(clear_cnt == 3, "R7", "clears before success", clear_cnt, 3);
    check(nlog == 3 * 11 + 39, "R6", "ops with 3 aborted attempts", nlog, 3 * 11 + 39);
    check(r_data == memf(8'h47), "R10", "fresh data after retry", r_data, memf(8'h47));
  endtask

  task automatic t_read_exhaust;
    run_cmd(1'b1, 8'h90, 8'h10, 8'h00);
    check(r_st == 2'd1, "R8", "read exhaust status", r_st, 1);
    check(clear_cnt == 10, "R8", "read attempts (clears)", clear_cnt, 10);
    check(nlog == 110, "R6", "read exhaust op count", nlog, 110);
    check(r_data == 8'h00, "R10", "failed read data", r_data, 0);
    check(bb_rsp == 1'b0, "R9", "bb_en after failure", bb_rsp, 0);
  endtask

  task automatic t_write_exhaust;
    run_cmd(1'b0, 8'h90, 8'h10, 8'h55);
    check(r_st == 2'd1, "R8", "write nack status", r_st, 1);
    check(clear_cnt == 1, "R8", "write attempts (clears)", clear_cnt, 1);
    check(nlog == 11, "R6", "write nack op count", nlog, 11);
  endtask

  task automatic t_write_line;
    err_left = 1;
    run_cmd(1'b0, 8'hA0, 8'h22, 8'h0F);
    check(r_st == 2'd2, "R11", "write line fault status", r_st, 2);
    check(clear_cnt == 1, "R11", "clears after line fault", clear_cnt, 1);
    check(nlog == 30, "R11", "ops after stop fault", nlog, 30);
  endtask

  task automatic t_read_line_retry;
    err_left = 1;
    run_cmd(1'b1, 8'hA0, 8'hC8, 8'h00);
    check(r_st == 2'd0, "R11", "read ok after line fault", r_st, 0);
    check(nlog == 39 + 1 + 39, "R11", "ops with one faulted read", nlog, 79);
    check(r_data == memf(8'hC8), "R10", "data after faulted attempt", r_data, memf(8'hC8));
  endtask

  bit finished = 0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_ok();
    t_read_ok(8'h81);
    t_read_ok(8'h00);
    t_read_ok(8'hFF);
    t_read_retry();
    t_read_exhaust();
    t_write_exhaust();
    t_write_line();
    t_read_line_retry();
    check(viol_backoff == 0, "R7", "back-off gap violations", viol_backoff, 0);
    check(viol_bb == 0, "R9", "ops without bb_en", viol_bb, 0);
    check(viol_busy == 0, "R1", "ready high during ops", viol_busy, 0);
    check(viol_gap == 0, "R1", "op_valid held after done", viol_gap, 0);
    finished = 1;
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fail_cnt++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end

endmodule